// File: doc/BRIEF.md
# Processor Cluster Control Register Block

This block is a bank of control and status registers for a processor cluster of four cores, reached over a plain 32-bit register bus with one-cycle write and read strobes. It holds a 64-bit boot address for each core and drives it out on a wide port. It carries a one-bit interrupt status with a mask that software changes only through a pair of write-one set and clear ports, and it raises a level interrupt when the status is set and not masked.

Software also writes per-core power-down requests. Each request drives a power-status output for that core. It also gates that core's wait-for-interrupt indication, so that the output only signals while the core is both idle and marked for power-down. A few further words (error, configuration, coherency and snoop control) are plain read/write storage. An internal event input sets the interrupt status.

Top module: `cluster_ctrl_top`

## Requirements
- R1: After reset, each boot-address low word reads 0xFFFF0000 and each high word reads 0. Configuration word 0 (0x20) reads 0x00000F0F, coherency control (0x80) reads 0x000F000F and the mask (0x14) reads 1. Status and all other words read 0, and irqOut, pwrStatOut and wfiOut are low.
- R2: Core i owns a low word at 0x40+8*i and a high word at 0x44+8*i. rstVecOut[64*i +: 64] equals {high, low} from the cycle after a write.
- R3: Status bit 0 (at 0x10) is set by evtIn and cleared by writing 1 to bit 0 of 0x10. When a set and a clear fall in the same cycle, the bit ends up set.
- R4: The mask at 0x14 ignores direct writes. Writing 1 in bit 0 of 0x18 clears it, and writing 1 in bit 0 of 0x1C sets it. A 0 in bit 0 of either has no effect, and both addresses read 0.
- R5: irqOut is high exactly when the status bit is 1 and the mask bit is 0, from the cycle after either one is updated.
- R6: Bits [3:0] of the power control word (0x90) are per-core power-down requests. pwrStatOut[i] follows request bit i from the cycle after the write and does not change on any other access.
- R7: wfiIn is captured into a register each cycle. wfiOut[i] is the AND of the captured bit i and power-down request bit i. Reset clears the captured state.
- R8: Words 0x00, 0x20, 0x24, 0x80 and 0x84 store and read back all 32 bits.
- R9: The power status word at 0x94 reads 0 and ignores writes in the bits of mask 0x0003000F. Its other bits are storage.
- R10: An access whose address bits [1:0] are not zero, or whose address maps to no word, changes nothing and reads 0. busRdData is 0 whenever busRdEn is low and shows the addressed word in the same cycle as busRdEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 8 | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational with busRdEn |
| evtIn | input | 1 | Internal event, sets status bit 0 |
| wfiIn | input | 4 | Per-core wait-for-interrupt from the cores |
| irqOut | output | 1 | Level interrupt |
| pwrStatOut | output | 4 | Per-core power-down request status |
| wfiOut | output | 4 | Per-core gated wait-for-interrupt |
| rstVecOut | output | 256 | Per-core 64-bit boot addresses, core 0 in the low bits |

## Verification
The event input that sets the interrupt status and a software write-one clear of that status can land on the same clock edge. The bench provokes this by raising evtIn in the same cycle as a write of 1 to 0x10. It then reads the status back and expects 1, because the set wins. A lone clear issued right after must read back 0, which shows the clear path itself works.

// File: rtl/cluster_ctrl_pkg.sv
package cluster_ctrl_pkg;

  localparam int DATA_W       = 32;
  localparam int CORE_FIELD_W = 4;

  // register byte offsets
  localparam int OFF_ERR     = 'h00;
  localparam int OFF_STAT    = 'h10;
  localparam int OFF_MASK    = 'h14;
  localparam int OFF_IEN     = 'h18;
  localparam int OFF_IDS     = 'h1C;
  localparam int OFF_CFG0    = 'h20;
  localparam int OFF_CFG1    = 'h24;
  localparam int OFF_VEC     = 'h40;
  localparam int OFF_ACE     = 'h80;
  localparam int OFF_SNOOP   = 'h84;
  localparam int OFF_PWR     = 'h90;
  localparam int OFF_PWRSTAT = 'h94;

  localparam logic [DATA_W-1:0] RST_VEC_LO   = 32'hFFFF_0000;
  localparam logic [DATA_W-1:0] RST_CFG0     = 32'h0000_0F0F;
  localparam logic [DATA_W-1:0] RST_ACE      = 32'h000F_000F;
  localparam logic [DATA_W-1:0] PWRSTAT_RO   = 32'h0003_000F;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_ERR, SEL_STAT, SEL_MASK, SEL_IEN, SEL_IDS, SEL_CFG0,
    SEL_CFG1, SEL_VEC, SEL_ACE, SEL_SNOOP, SEL_PWR, SEL_PWRSTAT
  } regSel_e;

  // strobes from the decode control to the register datapath
  typedef struct packed {
    logic                    wr;
    logic                    rd;
    regSel_e                 sel;
    logic [CORE_FIELD_W-1:0] core;
    logic                    hiWord;
  } busCmd_t;

endpackage

// File: rtl/cluster_ctrl_decode.sv
module cluster_ctrl_decode
  import cluster_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output busCmd_t           cmd
);

  localparam logic [ADDR_W-1:0] A_ERR     = ADDR_W'(OFF_ERR);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_IEN     = ADDR_W'(OFF_IEN);
  localparam logic [ADDR_W-1:0] A_IDS     = ADDR_W'(OFF_IDS);
  localparam logic [ADDR_W-1:0] A_CFG0    = ADDR_W'(OFF_CFG0);
  localparam logic [ADDR_W-1:0] A_CFG1    = ADDR_W'(OFF_CFG1);
  localparam logic [ADDR_W-1:0] A_ACE     = ADDR_W'(OFF_ACE);
  localparam logic [ADDR_W-1:0] A_SNOOP   = ADDR_W'(OFF_SNOOP);
  localparam logic [ADDR_W-1:0] A_PWR     = ADDR_W'(OFF_PWR);
  localparam logic [ADDR_W-1:0] A_PWRSTAT = ADDR_W'(OFF_PWRSTAT);
  localparam logic [ADDR_W-1:0] A_VEC     = ADDR_W'(OFF_VEC);
  localparam logic [ADDR_W:0]   A_VEC_END = (ADDR_W+1)'(OFF_VEC + 8 * NUM_CORES);

  logic              aligned;
  logic              inVec;
  logic [ADDR_W-1:0] vecOff;
  regSel_e           selRaw;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    inVec   = (busAddr >= A_VEC) && ({1'b0, busAddr} < A_VEC_END);
    vecOff  = busAddr - A_VEC;
    selRaw  = SEL_NONE;
    if (inVec) begin
      selRaw = SEL_VEC;
    end else begin
      case (busAddr)
        A_ERR:     selRaw = SEL_ERR;
        A_STAT:    selRaw = SEL_STAT;
        A_MASK:    selRaw = SEL_MASK;
        A_IEN:     selRaw = SEL_IEN;
        A_IDS:     selRaw = SEL_IDS;
        A_CFG0:    selRaw = SEL_CFG0;
        A_CFG1:    selRaw = SEL_CFG1;
        A_ACE:     selRaw = SEL_ACE;
        A_SNOOP:   selRaw = SEL_SNOOP;
        A_PWR:     selRaw = SEL_PWR;
        A_PWRSTAT: selRaw = SEL_PWRSTAT;
        default:   selRaw = SEL_NONE;
      endcase
    end

    cmd        = '0;
    cmd.sel    = aligned ? selRaw : SEL_NONE;
    cmd.core   = inVec ? CORE_FIELD_W'(vecOff >> 3) : '0;
    cmd.hiWord = busAddr[2];
    cmd.wr     = busWrEn && (cmd.sel != SEL_NONE);
    cmd.rd     = busRdEn && (cmd.sel != SEL_NONE);
  end

  AST_MISALIGNED_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> (!cmd.wr && !cmd.rd)) else $error("misaligned access passed"); // R10

endmodule

// File: rtl/cluster_ctrl_regs.sv
module cluster_ctrl_regs
  import cluster_ctrl_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  busCmd_t                   cmd,
  input  logic [DATA_W-1:0]         wrData,
  input  logic                      evtIn,
  input  logic [NUM_CORES-1:0]      wfiIn,
  output logic [DATA_W-1:0]         rdData,
  output logic                      irqOut,
  output logic [NUM_CORES-1:0]      pwrStatOut,
  output logic [NUM_CORES-1:0]      wfiOut,
  output logic [NUM_CORES*64-1:0]   rstVecOut
);

  localparam int CORE_IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

  logic [DATA_W-1:0]       errCtrl, cfg0, cfg1, aceCtrl, snoopCtrl, pwrCtrl, pwrStatReg;
  logic                    isrBit, imrBit;
  logic [NUM_CORES-1:0]    wfiSeen;
  logic [NUM_CORES*64-1:0] vecBus;
  logic [CORE_IDX_W-1:0]   coreIdx;

  function automatic logic hit(busCmd_t c, regSel_e s);
    return c.wr && (c.sel == s);
  endfunction

  // plain storage words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errCtrl    <= '0;
      cfg0       <= RST_CFG0;
      cfg1       <= '0;
      aceCtrl    <= RST_ACE;
      snoopCtrl  <= '0;
      pwrCtrl    <= '0;
      pwrStatReg <= '0;
    end else begin
      if (hit(cmd, SEL_ERR))     errCtrl    <= wrData;
      if (hit(cmd, SEL_CFG0))    cfg0       <= wrData;
      if (hit(cmd, SEL_CFG1))    cfg1       <= wrData;
      if (hit(cmd, SEL_ACE))     aceCtrl    <= wrData;
      if (hit(cmd, SEL_SNOOP))   snoopCtrl  <= wrData;
      if (hit(cmd, SEL_PWR))     pwrCtrl    <= wrData;
      if (hit(cmd, SEL_PWRSTAT)) pwrStatReg <= wrData & ~PWRSTAT_RO;
    end
  end

  // per-core boot address words
  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    logic [DATA_W-1:0] vecLo, vecHi;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecLo <= RST_VEC_LO;
        vecHi <= '0;
      end else if (hit(cmd, SEL_VEC) && (cmd.core == CORE_FIELD_W'(g))) begin
        if (cmd.hiWord) vecHi <= wrData;
        else            vecLo <= wrData;
      end
    end
    assign vecBus[g*64 +: 64] = {vecHi, vecLo};
  end

  assign rstVecOut = vecBus;

  // interrupt status and mask
  always_ff @(posedge clk) begin
    if (!rstN) begin
      isrBit <= 1'b0;
      imrBit <= 1'b1;
    end else begin
      if (evtIn)                                 isrBit <= 1'b1;
      else if (hit(cmd, SEL_STAT) && wrData[0])  isrBit <= 1'b0;
      if (hit(cmd, SEL_IEN) && wrData[0])        imrBit <= 1'b0;
      else if (hit(cmd, SEL_IDS) && wrData[0])   imrBit <= 1'b1;
    end
  end

  assign irqOut = isrBit & ~imrBit;

  // power-down requests and idle gating
  always_ff @(posedge clk) begin
    if (!rstN) wfiSeen <= '0;
    else       wfiSeen <= wfiIn;
  end

  assign pwrStatOut = pwrCtrl[NUM_CORES-1:0];
  assign wfiOut     = pwrCtrl[NUM_CORES-1:0] & wfiSeen;

  // read mux
  assign coreIdx = cmd.core[CORE_IDX_W-1:0];

  always_comb begin
    rdData = '0;
    if (cmd.rd) begin
      case (cmd.sel)
        SEL_ERR:     rdData = errCtrl;
        SEL_STAT:    rdData = {{(DATA_W-1){1'b0}}, isrBit};
        SEL_MASK:    rdData = {{(DATA_W-1){1'b0}}, imrBit};
        SEL_CFG0:    rdData = cfg0;
        SEL_CFG1:    rdData = cfg1;
        SEL_VEC:     rdData = vecBus[DATA_W*int'({coreIdx, cmd.hiWord}) +: DATA_W];
        SEL_ACE:     rdData = aceCtrl;
        SEL_SNOOP:   rdData = snoopCtrl;
        SEL_PWR:     rdData = pwrCtrl;
        SEL_PWRSTAT: rdData = pwrStatReg;
        default:     rdData = '0;
      endcase
    end
  end

  AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    evtIn |=> isrBit) else $error("event did not set status"); // R3
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (hit(cmd, SEL_STAT) && wrData[0] && !evtIn) |=> !isrBit) else $error("clear lost"); // R3
  AST_ENABLE_UNMASKS: assert property (@(posedge clk) disable iff (!rstN)
    (hit(cmd, SEL_IEN) && wrData[0]) |=> !imrBit) else $error("enable failed"); // R4
  AST_DISABLE_MASKS: assert property (@(posedge clk) disable iff (!rstN)
    (hit(cmd, SEL_IDS) && wrData[0]) |=> imrBit) else $error("disable failed"); // R4
  AST_PWRSTAT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !hit(cmd, SEL_PWR) |=> $stable(pwrStatOut)) else $error("power status moved"); // R6
  AST_WFI_GATED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wfiOut == (pwrStatOut & $past(wfiIn)))) else $error("idle gating wrong"); // R7

endmodule

// File: rtl/cluster_ctrl_top.sv
module cluster_ctrl_top
  import cluster_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_CORES = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busWrEn,
  input  logic                    busRdEn,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]       busWrData,
  output logic [DATA_W-1:0]       busRdData,
  input  logic                    evtIn,
  input  logic [NUM_CORES-1:0]    wfiIn,
  output logic                    irqOut,
  output logic [NUM_CORES-1:0]    pwrStatOut,
  output logic [NUM_CORES-1:0]    wfiOut,
  output logic [NUM_CORES*64-1:0] rstVecOut
);

  busCmd_t cmd;

  cluster_ctrl_decode #(.ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES)) u_decode (
    .clk     (clk),
    .rstN    (rstN),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .busAddr (busAddr),
    .cmd     (cmd)
  );

  cluster_ctrl_regs #(.NUM_CORES(NUM_CORES)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .wrData     (busWrData),
    .evtIn      (evtIn),
    .wfiIn      (wfiIn),
    .rdData     (busRdData),
    .irqOut     (irqOut),
    .pwrStatOut (pwrStatOut),
    .wfiOut     (wfiOut),
    .rstVecOut  (rstVecOut)
  );

endmodule

// File: tb/cluster_ctrl_top_tb.sv
module cluster_ctrl_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC      = 18;

  logic         clk = 1'b0;
  logic         rstN;
  logic         busWrEn, busRdEn;
  logic [7:0]   busAddr;
  logic [31:0]  busWrData, busRdData;
  logic         evtIn;
  logic [3:0]   wfiIn;
  logic         irqOut;
  logic [3:0]   pwrStatOut, wfiOut;
  logic [255:0] rstVecOut;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_ctrl_top u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .evtIn(evtIn), .wfiIn(wfiIn), .irqOut(irqOut), .pwrStatOut(pwrStatOut),
    .wfiOut(wfiOut), .rstVecOut(rstVecOut)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  // wr=1: write data; wr=0: read and expect data
  localparam vec_t VECS [N_VEC] = '{
    '{1'b1, 8'h00, 32'h1234_5678, 4'd8},   // R8
    '{1'b0, 8'h00, 32'h1234_5678, 4'd8},
    '{1'b1, 8'h20, 32'hA5A5_A5A5, 4'd8},
    '{1'b0, 8'h20, 32'hA5A5_A5A5, 4'd8},
    '{1'b1, 8'h24, 32'h0F1E_2D3C, 4'd8},
    '{1'b0, 8'h24, 32'h0F1E_2D3C, 4'd8},
    '{1'b1, 8'h84, 32'hCAFE_0001, 4'd8},
    '{1'b0, 8'h84, 32'hCAFE_0001, 4'd8},
    '{1'b1, 8'h94, 32'hFFFF_FFFF, 4'd9},   // R9
    '{1'b0, 8'h94, 32'hFFFC_FFF0, 4'd9},
    '{1'b1, 8'h14, 32'h0000_0000, 4'd4},   // R4 direct write ignored
    '{1'b1, 8'h18, 32'hFFFF_FFFE, 4'd4},   // R4 bit0 zero, no effect
    '{1'b0, 8'h14, 32'h0000_0001, 4'd4},
    '{1'b0, 8'h18, 32'h0000_0000, 4'd4},
    '{1'b0, 8'h1C, 32'h0000_0000, 4'd4},
    '{1'b1, 8'h22, 32'hFFFF_FFFF, 4'd10},  // R10 misaligned
    '{1'b0, 8'h20, 32'hA5A5_A5A5, 4'd10},
    '{1'b1, 8'h30, 32'h0000_0005, 4'd10}   // R10 unmapped
  };

  task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic readCheck(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    check(req, 256'(d), 256'(exp));
  endtask

  localparam logic [255:0] VEC_DEFAULT = {4{64'h0000_0000_FFFF_0000}};

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0;
    busWrData = '0; evtIn = 1'b0; wfiIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readCheck("R1 vec0 lo", 8'h40, 32'hFFFF_0000);
    readCheck("R1 vec3 lo", 8'h58, 32'hFFFF_0000);
    readCheck("R1 vec0 hi", 8'h44, 32'h0);
    readCheck("R1 cfg0", 8'h20, 32'h0000_0F0F);
    readCheck("R1 ace", 8'h80, 32'h000F_000F);
    readCheck("R1 mask", 8'h14, 32'h1);
    readCheck("R1 status", 8'h10, 32'h0);
    readCheck("R1 cfg1", 8'h24, 32'h0);
    check("R1 irqOut", 256'(irqOut), 256'(0));
    check("R1 pwrStatOut", 256'(pwrStatOut), 256'(0));
    check("R1 wfiOut", 256'(wfiOut), 256'(0));
    check("R1 rstVecOut", rstVecOut, VEC_DEFAULT);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      if (VECS[i].wr) begin
        busWrite(VECS[i].addr, VECS[i].data);
      end else begin
        logic [31:0] d;
        busRead(VECS[i].addr, d);
        nChecks++;
        if (d !== VECS[i].data) begin
          nFails++;
          $display("FAIL R%0d: read %0h actual %0h expected %0h",
                   VECS[i].req, VECS[i].addr, d, VECS[i].data);
        end
      end
    end
    readCheck("R10 unmapped read", 8'h30, 32'h0);
    readCheck("R10 misaligned read", 8'h21, 32'h0);
    busRdEn = 1'b0;
    #1 check("R10 idle read data", 256'(busRdData), 256'(0));

    // R2 boot addresses
    busWrite(8'h48, 32'h0000_1000);
    busWrite(8'h4C, 32'h0000_DEAD);
    check("R2 core1 vector", 256'(rstVecOut[127:64]), 256'(64'h0000_DEAD_0000_1000));
    check("R2 core0 untouched", 256'(rstVecOut[63:0]), 256'(64'h0000_0000_FFFF_0000));
    readCheck("R2 core1 hi readback", 8'h4C, 32'h0000_DEAD);

    // R3 set and clear in the same cycle
    @(negedge clk);
    evtIn = 1'b1; busWrEn = 1'b1; busAddr = 8'h10; busWrData = 32'h1;
    @(negedge clk);
    evtIn = 1'b0; busWrEn = 1'b0;
    readCheck("R3 set wins over clear", 8'h10, 32'h1);
    check("R5 masked no irq", 256'(irqOut), 256'(0));
    busWrite(8'h10, 32'h1);
    readCheck("R3 write-one clear", 8'h10, 32'h0);

    // R5 and R4 interrupt path
    @(negedge clk); evtIn = 1'b1;
    @(negedge clk); evtIn = 1'b0;
    check("R5 still masked", 256'(irqOut), 256'(0));
    busWrite(8'h18, 32'h1);
    check("R5 irq after enable", 256'(irqOut), 256'(1));
    readCheck("R4 mask cleared by enable", 8'h14, 32'h0);
    busWrite(8'h1C, 32'h1);
    check("R5 irq after disable", 256'(irqOut), 256'(0));
    readCheck("R4 mask set by disable", 8'h14, 32'h1);
    busWrite(8'h18, 32'h1);
    check("R5 irq re-enabled", 256'(irqOut), 256'(1));
    busWrite(8'h10, 32'h1);
    check("R5 irq drops on clear", 256'(irqOut), 256'(0));

    // R6 and R7 power-down requests and idle gating
    busWrite(8'h90, 32'h5);
    check("R6 power status", 256'(pwrStatOut), 256'(4'h5));
    readCheck("R6 power control readback", 8'h90, 32'h5);
    @(negedge clk); wfiIn = 4'hF;
    check("R7 not yet captured", 256'(wfiOut), 256'(0));
    @(negedge clk);
    check("R7 gated idle", 256'(wfiOut), 256'(4'h5));
    busWrite(8'h90, 32'h13);
    check("R6 new requests", 256'(pwrStatOut), 256'(4'h3));
    check("R7 follows requests", 256'(wfiOut), 256'(4'h3));
    busWrite(8'h20, 32'h0);
    check("R6 other write no change", 256'(pwrStatOut), 256'(4'h3));
    @(negedge clk); wfiIn = 4'h0;
    @(negedge clk);
    check("R7 idle released", 256'(wfiOut), 256'(0));

    // R1 and R7 reset in mid-run
    wfiIn = 4'hF;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 power status after reset", 256'(pwrStatOut), 256'(0));
    check("R7 wfi cleared by reset", 256'(wfiOut), 256'(0));
    check("R1 vectors after reset", rstVecOut, VEC_DEFAULT);
    readCheck("R1 mask after reset", 8'h14, 32'h1);
    rstN = 1'b1;
    wfiIn = 4'h0;
    @(negedge clk);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule